// File: doc/BRIEF.md
# Shared Power Vote Resolver

Several requesters can share one power island, and each may want that island in a different power state. This block keeps a small vote table for every island. Each entry records a requester identifier and the last state that requester asked for. When a new vote arrives, the block first looks for the requester's existing entry. If there is none, it takes a free entry. It then resolves the state the island may safely enter, which is the least deep state still wanted by any entry.

Power states are two-bit codes. Code 0 is fully on and code 3 is the deepest supported off state. A smaller code is therefore a shallower state, and the resolved state is the numeric minimum over the island's entries.

A vote is presented with a valid/ready handshake. The block reads the four entries of the addressed island one per cycle. It then writes the vote and reports the resolved state together with the island index on a one-cycle done pulse. If the table has no room for a new requester, the vote is not stored and an overflow flag accompanies the result.

Top module: `power_vote_resolver`

## Requirements
- R1: `req_ready_o` is high whenever no vote is being processed. A vote is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` then stays low until the cycle in which that vote's `done_o` is high.
- R2: `done_o` is high for exactly one cycle, in the cycle that follows the fifth rising edge after the accepting edge (SLOTS+1 edges). In that cycle `done_island_o` equals the accepted island index.
- R3: The 3-bit `req_state_i` is clamped before it is stored or compared. Values 4 to 7 act as state 3, and values 0 to 3 pass unchanged.
- R4: If the island already holds an occupied entry with the same requester identifier, that entry's state is replaced by the new clamped state.
- R5: With no matching entry, the vote is written into the lowest-numbered free entry of the island, which is then occupied.
- R6: With no matching entry and no free entry, the vote is not stored and `overflow_o` is high in the done cycle. The result is the minimum of the clamped requested state and the four stored states.
- R7: Without overflow, `done_state_o` is the minimum over the island's four entries after the write. The minimum starts from state 3, and free entries contribute state 3.
- R8: After reset, every entry of every island is free with state 3, `req_ready_o` is 1, and `done_o` and `overflow_o` are 0. Votes from before a reset have no effect after it.
- R9: A vote changes only the table of the island it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Vote is presented |
| req_ready_o | output | 1 | Block can take a vote |
| req_island_i | input | 6 | Island index of the vote |
| req_id_i | input | 8 | Requester identifier |
| req_state_i | input | 3 | Requested power state, clamped to 0..3 |
| done_o | output | 1 | One-cycle result strobe |
| done_island_o | output | 6 | Island index of the result |
| done_state_o | output | 2 | Resolved power state for the island |
| overflow_o | output | 1 | The vote could not be stored (valid with done_o) |

## Verification
The hardest situation to reach is a full island receiving a vote from a fifth requester. In that case the vote must shape the result while leaving no trace in the table. The stimulus fills one island with four requesters at state 3. It then sends a shallow vote from a fifth identifier, which must yield that shallow state with the overflow flag set. A following deep vote from yet another identifier must return state 3, which shows that the shallow vote was never stored. A long run of random votes over only a few islands and six identifiers then reaches overflow, replacement and allocation many times, checked against a reference table kept in the bench.

// File: rtl/pvr_pkg.sv
package pvr_pkg;

   localparam int unsigned PWR_W = 2;

   typedef logic [PWR_W-1:0] pwr_t;

   localparam pwr_t PWR_DEEPEST = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SCAN,
      ST_RESOLVE
   } fsm_t;

   // Limit a raw request code to the supported range of power states
   function automatic pwr_t clamp_pwr(input logic [7:0] raw);
      if (raw > 8'(PWR_DEEPEST)) begin
         return PWR_DEEPEST;
      end
      return raw[PWR_W-1:0];
   endfunction

endpackage

// File: rtl/pvr_vote_table.sv
module pvr_vote_table
   import pvr_pkg::*;
#(
   parameter int unsigned ISLANDS = 64,
   parameter int unsigned SLOTS   = 4,
   parameter int unsigned ID_W    = 8,
   localparam int unsigned ISL_W  = (ISLANDS > 1) ? $clog2(ISLANDS) : 1,
   localparam int unsigned IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ISL_W-1:0] rd_island_i,
   input  logic [IDX_W-1:0] rd_slot_i,
   output logic             rd_valid_o,
   output logic [ID_W-1:0]  rd_id_o,
   output pwr_t             rd_pwr_o,
   input  logic             wr_en_i,
   input  logic [ISL_W-1:0] wr_island_i,
   input  logic [IDX_W-1:0] wr_slot_i,
   input  logic [ID_W-1:0]  wr_id_i,
   input  pwr_t             wr_pwr_i
);

   logic            occ_q [ISLANDS][SLOTS];
   logic [ID_W-1:0] who_q [ISLANDS][SLOTS];
   pwr_t            lvl_q [ISLANDS][SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(ISLANDS); i++) begin
            for (int s = 0; s < int'(SLOTS); s++) begin
               occ_q[i][s] <= 1'b0;
               who_q[i][s] <= '0;
               lvl_q[i][s] <= PWR_DEEPEST;
            end
         end
      end else if (wr_en_i) begin
         occ_q[wr_island_i][wr_slot_i] <= 1'b1;
         who_q[wr_island_i][wr_slot_i] <= wr_id_i;
         lvl_q[wr_island_i][wr_slot_i] <= wr_pwr_i;
      end
   end

   assign rd_valid_o = occ_q[rd_island_i][rd_slot_i];
   assign rd_id_o    = who_q[rd_island_i][rd_slot_i];
   assign rd_pwr_o   = lvl_q[rd_island_i][rd_slot_i];

   // R5: a written entry becomes occupied and holds the written state
   a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (occ_q[$past(wr_island_i)][$past(wr_slot_i)] &&
                   lvl_q[$past(wr_island_i)][$past(wr_slot_i)] == $past(wr_pwr_i)))
      else $error("vote table write did not land");

endmodule

// File: rtl/pvr_slot_scan.sv
module pvr_slot_scan
   import pvr_pkg::*;
#(
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned ID_W   = 8,
   localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic                   step_i,
   input  logic [IDX_W-1:0]       step_idx_i,
   input  logic [ID_W-1:0]        key_id_i,
   input  logic                   rd_valid_i,
   input  logic [ID_W-1:0]        rd_id_i,
   input  pwr_t                   rd_pwr_i,
   output logic                   hit_o,
   output logic [IDX_W-1:0]       hit_idx_o,
   output logic                   free_o,
   output logic [IDX_W-1:0]       free_idx_o,
   output pwr_t [SLOTS-1:0]       snap_o
);

   logic             hit_q, free_q;
   logic [IDX_W-1:0] hit_idx_q, free_idx_q;
   pwr_t [SLOTS-1:0] snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q      <= 1'b0;
         free_q     <= 1'b0;
         hit_idx_q  <= '0;
         free_idx_q <= '0;
         snap_q     <= {SLOTS{PWR_DEEPEST}};
      end else if (start_i) begin
         hit_q  <= 1'b0;
         free_q <= 1'b0;
      end else if (step_i) begin
         snap_q[step_idx_i] <= rd_pwr_i;
         if (rd_valid_i && (rd_id_i == key_id_i) && !hit_q) begin
            hit_q     <= 1'b1;
            hit_idx_q <= step_idx_i;
         end
         if (!rd_valid_i && !free_q) begin
            free_q     <= 1'b1;
            free_idx_q <= step_idx_i;
         end
      end
   end

   assign hit_o      = hit_q;
   assign hit_idx_o  = hit_idx_q;
   assign free_o     = free_q;
   assign free_idx_o = free_idx_q;
   assign snap_o     = snap_q;

   // R5: the first free entry found keeps its index for the rest of the scan
   a_r5_first_free_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (free_q && step_i && !start_i) |=> (free_q && free_idx_q == $past(free_idx_q)))
      else $error("free entry index moved during scan");

   // R4: a matching entry, once found, is not displaced by a later one
   a_r4_match_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && step_i && !start_i) |=> (hit_q && hit_idx_q == $past(hit_idx_q)))
      else $error("match index moved during scan");

endmodule

// File: rtl/pvr_min_reduce.sv
module pvr_min_reduce
   import pvr_pkg::*;
#(
   parameter int unsigned SLOTS  = 4,
   localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  pwr_t             seed_i,
   input  pwr_t [SLOTS-1:0] states_i,
   input  logic             replace_en_i,
   input  logic [IDX_W-1:0] replace_idx_i,
   input  pwr_t             replace_pwr_i,
   output pwr_t             result_o
);

   pwr_t chain [SLOTS+1];

   assign chain[0] = seed_i;

   for (genvar s = 0; s < int'(SLOTS); s++) begin : g_lane
      pwr_t eff;
      assign eff = (replace_en_i && (replace_idx_i == IDX_W'(s))) ? replace_pwr_i
                                                                 : states_i[s];
      assign chain[s+1] = (eff < chain[s]) ? eff : chain[s];
   end

   assign result_o = chain[SLOTS];

   // R7: the minimum never lies above its seed nor above a freshly written vote
   always_comb begin
      a_r7_not_above_seed: assert (result_o <= seed_i)
         else $error("minimum above seed");
      if (replace_en_i) begin
         a_r7_not_above_new: assert (result_o <= replace_pwr_i)
            else $error("minimum above new vote");
      end
   end

endmodule

// File: rtl/power_vote_resolver.sv
module power_vote_resolver
   import pvr_pkg::*;
#(
   parameter int unsigned ISLANDS = 64,
   parameter int unsigned SLOTS   = 4,
   parameter int unsigned ID_W    = 8,
   parameter int unsigned REQ_W   = 3,
   localparam int unsigned ISL_W  = (ISLANDS > 1) ? $clog2(ISLANDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid_i,
   output logic             req_ready_o,
   input  logic [ISL_W-1:0] req_island_i,
   input  logic [ID_W-1:0]  req_id_i,
   input  logic [REQ_W-1:0] req_state_i,
   output logic             done_o,
   output logic [ISL_W-1:0] done_island_o,
   output logic [1:0]       done_state_o,
   output logic             overflow_o
);

   localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

   if (SLOTS < 2 || (1 << IDX_W) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two and at least 2");
   end
   if (ISLANDS < 2 || (1 << ISL_W) != ISLANDS) begin : g_bad_islands
      $error("ISLANDS must be a power of two and at least 2");
   end
   if (REQ_W < PWR_W || REQ_W > 8) begin : g_bad_req
      $error("REQ_W must lie between the state width and 8");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("ID_W must be at least 1");
   end

   fsm_t             fsm_q;
   logic [ISL_W-1:0] isl_q;
   logic [ID_W-1:0]  id_q;
   pwr_t             pwr_q;
   logic [IDX_W-1:0] cnt_q;

   logic accept;
   assign req_ready_o = (fsm_q == ST_IDLE);
   assign accept      = req_valid_i && req_ready_o;

   // table read port and scanner
   logic             rd_valid;
   logic [ID_W-1:0]  rd_id;
   pwr_t             rd_pwr;
   logic             hit, free;
   logic [IDX_W-1:0] hit_idx, free_idx;
   pwr_t [SLOTS-1:0] snap;

   // resolve stage
   logic             resolving, ovf_w, wr_en;
   logic [IDX_W-1:0] tgt_idx;
   pwr_t             seed, result;

   assign resolving = (fsm_q == ST_RESOLVE);
   assign ovf_w     = !hit && !free;
   assign tgt_idx   = hit ? hit_idx : free_idx;
   assign wr_en     = resolving && !ovf_w;
   assign seed      = ovf_w ? pwr_q : PWR_DEEPEST;

   pvr_vote_table #(
      .ISLANDS (ISLANDS),
      .SLOTS   (SLOTS),
      .ID_W    (ID_W)
   ) i_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_island_i (isl_q),
      .rd_slot_i   (cnt_q),
      .rd_valid_o  (rd_valid),
      .rd_id_o     (rd_id),
      .rd_pwr_o    (rd_pwr),
      .wr_en_i     (wr_en),
      .wr_island_i (isl_q),
      .wr_slot_i   (tgt_idx),
      .wr_id_i     (id_q),
      .wr_pwr_i    (pwr_q)
   );

   pvr_slot_scan #(
      .SLOTS (SLOTS),
      .ID_W  (ID_W)
   ) i_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (accept),
      .step_i     (fsm_q == ST_SCAN),
      .step_idx_i (cnt_q),
      .key_id_i   (id_q),
      .rd_valid_i (rd_valid),
      .rd_id_i    (rd_id),
      .rd_pwr_i   (rd_pwr),
      .hit_o      (hit),
      .hit_idx_o  (hit_idx),
      .free_o     (free),
      .free_idx_o (free_idx),
      .snap_o     (snap)
   );

   pvr_min_reduce #(
      .SLOTS (SLOTS)
   ) i_reduce (
      .seed_i        (seed),
      .states_i      (snap),
      .replace_en_i  (!ovf_w),
      .replace_idx_i (tgt_idx),
      .replace_pwr_i (pwr_q),
      .result_o      (result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q         <= ST_IDLE;
         isl_q         <= '0;
         id_q          <= '0;
         pwr_q         <= PWR_DEEPEST;
         cnt_q         <= '0;
         done_o        <= 1'b0;
         done_island_o <= '0;
         done_state_o  <= PWR_DEEPEST;
         overflow_o    <= 1'b0;
      end else begin
         done_o     <= 1'b0;
         overflow_o <= 1'b0;
         unique case (fsm_q)
            ST_IDLE: begin
               if (accept) begin
                  isl_q <= req_island_i;
                  id_q  <= req_id_i;
                  pwr_q <= clamp_pwr(8'(req_state_i));
                  cnt_q <= '0;
                  fsm_q <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_IDX) begin
                  fsm_q <= ST_RESOLVE;
               end
            end
            ST_RESOLVE: begin
               done_o        <= 1'b1;
               done_island_o <= isl_q;
               done_state_o  <= result;
               overflow_o    <= ovf_w;
               fsm_q         <= ST_IDLE;
            end
            default: fsm_q <= ST_IDLE;
         endcase
      end
   end

   // R1: an accepted vote makes the block busy on the next cycle
   a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready_o)
      else $error("ready stayed high after accept");

   // R2: the result strobe lasts one cycle
   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("done lasted more than one cycle");

   // R6: overflow is only reported together with a result
   a_r6_overflow_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |-> done_o)
      else $error("overflow without done");

   // R3: the resolved state never lies deeper than the clamped vote
   a_r3_result_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (done_state_o <= pwr_q))
      else $error("result deeper than the vote");

endmodule

// File: tb/test_power_vote_resolver.sv
module test_power_vote_resolver;

   localparam int CLK_PERIOD = 10;
   localparam int NISL  = 64;
   localparam int NSLOT = 4;
   localparam int LAT   = NSLOT + 1;
   localparam int WD_LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid_i = 1'b0;
   logic       req_ready_o;
   logic [5:0] req_island_i = '0;
   logic [7:0] req_id_i = '0;
   logic [2:0] req_state_i = '0;
   logic       done_o;
   logic [5:0] done_island_o;
   logic [1:0] done_state_o;
   logic       overflow_o;

   power_vote_resolver i_power_vote_resolver (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid_i   (req_valid_i),
      .req_ready_o   (req_ready_o),
      .req_island_i  (req_island_i),
      .req_id_i      (req_id_i),
      .req_state_i   (req_state_i),
      .done_o        (done_o),
      .done_island_o (done_island_o),
      .done_state_o  (done_state_o),
      .overflow_o    (overflow_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   int checks = 0;
   int errors = 0;

   typedef struct {
      int    isl;
      int    st;
      bit    ovf;
      int    due;
      string tag;
   } exp_t;

   exp_t exp_q[$];

   // reference vote table
   bit m_occ [NISL][NSLOT];
   int m_id  [NISL][NSLOT];
   int m_st  [NISL][NSLOT];

   task automatic model_clear();
      for (int i = 0; i < NISL; i++)
         for (int s = 0; s < NSLOT; s++) begin
            m_occ[i][s] = 1'b0;
            m_id[i][s]  = 0;
            m_st[i][s]  = 3;
         end
   endtask

   task automatic model_vote(input int isl, input int id, input int raw,
                             output int res, output bit ovf);
      int st;
      int slot;
      st = (raw > 3) ? 3 : raw;
      slot = -1;
      for (int s = 0; s < NSLOT; s++)
         if (slot < 0 && m_occ[isl][s] && m_id[isl][s] == id) slot = s;
      for (int s = 0; s < NSLOT; s++)
         if (slot < 0 && !m_occ[isl][s]) slot = s;
      if (slot >= 0) begin
         m_occ[isl][slot] = 1'b1;
         m_id[isl][slot]  = id;
         m_st[isl][slot]  = st;
         res = 3;
         ovf = 1'b0;
      end else begin
         res = st;
         ovf = 1'b1;
      end
      for (int s = 0; s < NSLOT; s++)
         if (m_st[isl][s] < res) res = m_st[isl][s];
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT) begin
         errors++;
         $display("FAIL R2 watchdog: got %0d cycles expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // monitor: pop and compare on every result strobe
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(cyc == e.due, "R2", "done cycle", cyc, e.due);
            check(int'(done_island_o) == e.isl, "R2", "island", done_island_o, e.isl);
            check(int'(done_state_o) == e.st, e.tag, "state", done_state_o, e.st);
            check(overflow_o == e.ovf, "R6", "overflow", overflow_o, e.ovf);
         end
      end
   end

   // driver: present one vote and push its expected result
   task automatic send(input int isl, input int id, input int raw, input string tag);
      int res;
      bit ovf;
      exp_t e;
      @(negedge clk);
      while (!req_ready_o) @(negedge clk);
      req_valid_i  = 1'b1;
      req_island_i = 6'(isl);
      req_id_i     = 8'(id);
      req_state_i  = 3'(raw);
      @(posedge clk);
      #1;
      req_valid_i = 1'b0;
      model_vote(isl, id, raw, res, ovf);
      e.isl = isl;
      e.st  = res;
      e.ovf = ovf;
      e.due = cyc + LAT;
      e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      check(req_ready_o == 1'b0, "R1", "ready while busy", req_ready_o, 0);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_idle(input string why);
      check(req_ready_o == 1'b1, "R8", {why, " ready"}, req_ready_o, 1);
      check(done_o == 1'b0, "R8", {why, " done"}, done_o, 0);
      check(overflow_o == 1'b0, "R8", {why, " overflow"}, overflow_o, 0);
   endtask

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      check_idle("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("after reset");

      // R8: fresh island resolves to the deepest state
      send(20, 7, 3, "R8");
      // R7: a single shallow vote wins over free entries
      send(5, 10, 1, "R7");
      // R4: same requester replaces its own vote
      send(5, 10, 2, "R4");
      // R5: new requesters allocate free entries
      send(5, 11, 0, "R5");
      send(5, 12, 3, "R5");
      send(5, 13, 3, "R5");
      // R4: releasing the shallow vote raises the result
      send(5, 11, 3, "R4");
      // R6: full island, overflow vote seeds the result
      send(7, 1, 3, "R6");
      send(7, 2, 3, "R6");
      send(7, 3, 3, "R6");
      send(7, 4, 3, "R6");
      send(7, 5, 1, "R6");
      send(7, 6, 3, "R6");
      // R4: existing entry still updated on a full island
      send(7, 2, 0, "R4");
      // R3: clamping of deep codes
      send(9, 1, 7, "R3");
      send(9, 2, 2, "R3");
      send(9, 1, 5, "R3");
      send(9, 2, 4, "R3");
      // R9: boundary islands stay independent
      send(0, 1, 0, "R9");
      send(63, 1, 2, "R9");
      send(0, 1, 3, "R9");
      send(63, 2, 3, "R9");
      send(5, 99, 3, "R9");
      drain();

      // R8: reset in mid-run wipes all votes
      rst_n = 1'b0;
      model_clear();
      repeat (2) @(negedge clk);
      check_idle("in second reset");
      rst_n = 1'b1;
      @(negedge clk);
      send(5, 99, 3, "R8");
      send(7, 50, 3, "R8");

      // random mix over few islands and identifiers
      for (int n = 0; n < 300; n++) begin
         send(int'($urandom_range(3, 0)), int'($urandom_range(5, 0)),
              int'($urandom_range(7, 0)), "R7");
      end
      drain();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule